// File: doc/BRIEF.md
# Audio FIFO Status and Interrupt Unit

This unit sits between a processor register bus and the serial audio link of a stereo port. It keeps two queues of 32-bit stereo words, each sixteen entries deep: an outbound queue that software or DMA fills and the link drains, and an inbound queue that the link fills and software or DMA drains. Both queues share one data address. Reading that address takes the oldest inbound word, and writing it appends an outbound word.

Software programs a fill threshold for each queue. The unit turns the fill levels into service requests, which drive the DMA request lines directly. Lost words are recorded in two sticky error flags: a link push into a full inbound queue, and a link pull from an empty outbound queue. Software clears these flags by writing ones to a clear register. A mask register picks which of the four conditions raise the single interrupt line. A status register reports the queue, error and link state. Serial shifting and clock generation are outside this unit.

Top module: `afs_irq_unit`

## Requirements
- R1: After reset both queues are empty, both error flags and the mask are clear, the link is disabled, and both thresholds are 0. The status register (word address 1) then reads 0x99, the interrupt is low, and both DMA requests are high.
- R2: Word addresses are: 0 control, 1 status, 2 mask, 3 clear, 4 data. A bus write to address 4 appends to the outbound queue. A bus read of address 4 returns and removes the oldest inbound word. Both queues are first in, first out, and sixteen reads drain a full inbound queue.
- R3: A read of address 4 while the inbound queue is empty returns 0 and leaves the queue unchanged. A write to address 4 while the outbound queue holds sixteen words is dropped.
- R4: Status bit 4 and `dma_rx_req` are high exactly while the inbound fill level is greater than or equal to control bits 15:12.
- R5: Status bit 3 and `dma_tx_req` are high exactly while the outbound fill level is less than or equal to control bits 11:8.
- R6: When the link pushes a word while the inbound queue is full, that word is lost and status bit 6 is set. The bit stays set until it is cleared.
- R7: When the link pulls a word while the outbound queue is empty, `tx_word` reads 0 and status bit 5 is set. The bit stays set until it is cleared.
- R8: Writing 1 to bit 6 or bit 5 of the clear register (address 3) clears the matching error flag, and zero bits have no effect. When an error event and its clear fall in the same cycle, the flag ends up set.
- R9: `irq` equals the OR over bits 6:3 of status ANDed with the mask register (address 2). The mask register reads back bits 6:3 only.
- R10: A control write with bit 3 set empties both queues and clears both error flags. Bit 3 always reads back as 0, while bits 15:12, 11:8 and 0 read back as written.
- R11: Control bit 0 enables the link. Status bit 7 is its inverse. While the link is disabled, link pushes and pulls are ignored. Status bit 2 (busy) is high only while the link is enabled and `frame_active` is high.
- R12: Status bit 1 is high while the inbound queue is not empty, and status bit 0 is high while the outbound queue is not full.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Bus write strobe |
| reg_rd | input | 1 | Bus read strobe; a read of the data address pops on the clock edge |
| reg_addr | input | AW | Word address |
| reg_wdata | input | DATA_W | Bus write data |
| reg_rdata | output | DATA_W | Bus read data, combinational from the address |
| tx_pull | input | 1 | Link takes the head outbound word at the clock edge |
| tx_word | output | DATA_W | Head outbound word, 0 when empty |
| rx_push | input | 1 | Link delivers `rx_word` at the clock edge |
| rx_word | input | DATA_W | Inbound word from the link |
| frame_active | input | 1 | Link reports a frame in progress |
| irq | output | 1 | Interrupt request |
| dma_rx_req | output | 1 | Inbound service request |
| dma_tx_req | output | 1 | Outbound service request |

## Verification
The hardest situation to reach is an error event that lands in the same cycle as the write that clears it. From the ports this takes a link pull on an empty outbound queue issued on exactly the same edge as a bus write of 0x20 to the clear register. The bench drives both strobes from one task at one falling edge, then reads status to confirm the flag survived. Overrun needs seventeen link pushes with no reads in between. The bench then drains the queue to show the seventeenth word was dropped while the flag stayed set.

// File: rtl/afs_pkg.sv
package afs_pkg;
   // status bit positions
   localparam int unsigned ST_TXNF  = 0;
   localparam int unsigned ST_RXNE  = 1;
   localparam int unsigned ST_BUSY  = 2;
   localparam int unsigned ST_TXSVC = 3;
   localparam int unsigned ST_RXSVC = 4;
   localparam int unsigned ST_UDR   = 5;
   localparam int unsigned ST_OVR   = 6;
   localparam int unsigned ST_OFF   = 7;
   // control field positions
   localparam int unsigned CTL_EN    = 0;
   localparam int unsigned CTL_FLUSH = 3;
   localparam int unsigned CTL_TXTH  = 8;
   localparam int unsigned CTL_RXTH  = 12;
   // interrupt sources occupy status bits 6:3
   localparam int unsigned SRC_LSB = 3;
   localparam int unsigned SRC_N   = 4;

   typedef enum logic [2:0] {
      SEL_CTRL = 3'd0,
      SEL_STAT = 3'd1,
      SEL_MASK = 3'd2,
      SEL_CLR  = 3'd3,
      SEL_DATA = 3'd4
   } afs_sel_e;
endpackage

// File: rtl/afs_fifo.sv
module afs_fifo #(
   parameter int DATA_W = 32,
   parameter int DEPTH  = 16
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          flush,
   input  logic                          push,
   input  logic [DATA_W-1:0]             wdata,
   input  logic                          pop,
   output logic [DATA_W-1:0]             head,
   output logic [$clog2(DEPTH+1)-1:0]    level,
   output logic                          empty,
   output logic                          full
);
   localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
   localparam int LVL_W = $clog2(DEPTH + 1);
   localparam bit POW2  = (DEPTH == (1 << PTR_W));

   logic [DATA_W-1:0] mem [DEPTH];
   logic [PTR_W-1:0]  wr_ptr, rd_ptr, wr_nxt, rd_nxt;
   logic              do_push, do_pop;

   assign empty   = (level == '0);
   assign full    = (level == LVL_W'(DEPTH));
   assign do_push = push && !full;
   assign do_pop  = pop && !empty;
   assign head    = empty ? '0 : mem[rd_ptr];

   generate
      if (POW2) begin : g_wrap_nat
         assign wr_nxt = wr_ptr + PTR_W'(1);
         assign rd_nxt = rd_ptr + PTR_W'(1);
      end else begin : g_wrap_cmp
         assign wr_nxt = (wr_ptr == PTR_W'(DEPTH - 1)) ? '0 : wr_ptr + PTR_W'(1);
         assign rd_nxt = (rd_ptr == PTR_W'(DEPTH - 1)) ? '0 : rd_ptr + PTR_W'(1);
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         level  <= '0;
      end else if (flush) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         level  <= '0;
      end else begin
         if (do_push) wr_ptr <= wr_nxt;
         if (do_pop)  rd_ptr <= rd_nxt;
         if (do_push && !do_pop)      level <= level + LVL_W'(1);
         else if (do_pop && !do_push) level <= level - LVL_W'(1);
      end
   end

   always_ff @(posedge clk) begin
      if (do_push && !flush) mem[wr_ptr] <= wdata;
   end
endmodule

// File: rtl/afs_flags.sv
module afs_flags
   import afs_pkg::*;
(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             flush,
   input  logic [1:0]       evt,      // [1] overrun, [0] underrun
   input  logic [1:0]       clr,
   input  logic             mask_we,
   input  logic [SRC_N-1:0] mask_wdata,
   input  logic             rx_svc,
   input  logic             tx_svc,
   output logic [1:0]       sticky,
   output logic [SRC_N-1:0] mask,
   output logic             irq
);
   generate
      for (genvar g = 0; g < 2; g++) begin : g_sticky
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)        sticky[g] <= 1'b0;
            else if (flush)    sticky[g] <= 1'b0;
            else if (evt[g])   sticky[g] <= 1'b1;
            else if (clr[g])   sticky[g] <= 1'b0;
         end
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       mask <= '0;
      else if (mask_we) mask <= mask_wdata;
   end

   assign irq = |({sticky[1], sticky[0], rx_svc, tx_svc} & mask);
endmodule

// File: rtl/afs_irq_unit.sv
module afs_irq_unit
   import afs_pkg::*;
#(
   parameter int DATA_W = 32,
   parameter int DEPTH  = 16,
   parameter int TH_W   = 4,
   parameter int AW     = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_wr,
   input  logic              reg_rd,
   input  logic [AW-1:0]     reg_addr,
   input  logic [DATA_W-1:0] reg_wdata,
   output logic [DATA_W-1:0] reg_rdata,
   input  logic              tx_pull,
   output logic [DATA_W-1:0] tx_word,
   input  logic              rx_push,
   input  logic [DATA_W-1:0] rx_word,
   input  logic              frame_active,
   output logic              irq,
   output logic              dma_rx_req,
   output logic              dma_tx_req
);
   localparam int LVL_W = $clog2(DEPTH + 1);
   localparam int CMP_W = (LVL_W > TH_W) ? LVL_W : TH_W;

   generate
      if (DATA_W < 16) begin : g_bad_width
         $error("afs_irq_unit: DATA_W must be at least 16");
      end
      if (TH_W < 1 || TH_W > 4) begin : g_bad_th
         $error("afs_irq_unit: TH_W must be 1..4");
      end
      if (AW < 3) begin : g_bad_aw
         $error("afs_irq_unit: AW must be at least 3");
      end
      if (DEPTH < 2) begin : g_bad_depth
         $error("afs_irq_unit: DEPTH must be at least 2");
      end
   endgenerate

   logic sel_ctrl, sel_mask, sel_clr, sel_data, sel_stat;
   assign sel_ctrl = (reg_addr == AW'(SEL_CTRL));
   assign sel_stat = (reg_addr == AW'(SEL_STAT));
   assign sel_mask = (reg_addr == AW'(SEL_MASK));
   assign sel_clr  = (reg_addr == AW'(SEL_CLR));
   assign sel_data = (reg_addr == AW'(SEL_DATA));

   logic            en_q;
   logic [TH_W-1:0] rx_th_q, tx_th_q;
   logic            flush;

   assign flush = reg_wr && sel_ctrl && reg_wdata[CTL_FLUSH];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en_q    <= 1'b0;
         rx_th_q <= '0;
         tx_th_q <= '0;
      end else if (reg_wr && sel_ctrl) begin
         en_q    <= reg_wdata[CTL_EN];
         rx_th_q <= reg_wdata[CTL_RXTH +: TH_W];
         tx_th_q <= reg_wdata[CTL_TXTH +: TH_W];
      end
   end

   logic [DATA_W-1:0] rx_head;
   logic [LVL_W-1:0]  rx_level, tx_level;
   logic              rx_empty, rx_full, tx_empty, tx_full;
   logic              rx_in, tx_out;

   assign rx_in  = rx_push && en_q;
   assign tx_out = tx_pull && en_q;

   afs_fifo #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_rx_q (
      .clk(clk), .rst_n(rst_n), .flush(flush),
      .push(rx_in), .wdata(rx_word),
      .pop(reg_rd && sel_data), .head(rx_head),
      .level(rx_level), .empty(rx_empty), .full(rx_full)
   );

   afs_fifo #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_tx_q (
      .clk(clk), .rst_n(rst_n), .flush(flush),
      .push(reg_wr && sel_data), .wdata(reg_wdata),
      .pop(tx_out), .head(tx_word),
      .level(tx_level), .empty(tx_empty), .full(tx_full)
   );

   logic rx_svc, tx_svc, busy;
   assign rx_svc = CMP_W'(rx_level) >= CMP_W'(rx_th_q);
   assign tx_svc = CMP_W'(tx_level) <= CMP_W'(tx_th_q);
   assign busy   = en_q && frame_active;
   assign dma_rx_req = rx_svc;
   assign dma_tx_req = tx_svc;

   logic [1:0]       sticky;
   logic [SRC_N-1:0] mask;

   afs_flags u_flags (
      .clk(clk), .rst_n(rst_n), .flush(flush),
      .evt({rx_in && rx_full, tx_out && tx_empty}),
      .clr({reg_wr && sel_clr && reg_wdata[ST_OVR],
            reg_wr && sel_clr && reg_wdata[ST_UDR]}),
      .mask_we(reg_wr && sel_mask),
      .mask_wdata(reg_wdata[SRC_LSB +: SRC_N]),
      .rx_svc(rx_svc), .tx_svc(tx_svc),
      .sticky(sticky), .mask(mask), .irq(irq)
   );

   logic [7:0] status;
   always_comb begin
      status           = '0;
      status[ST_OFF]   = !en_q;
      status[ST_OVR]   = sticky[1];
      status[ST_UDR]   = sticky[0];
      status[ST_RXSVC] = rx_svc;
      status[ST_TXSVC] = tx_svc;
      status[ST_BUSY]  = busy;
      status[ST_RXNE]  = !rx_empty;
      status[ST_TXNF]  = !tx_full;
   end

   always_comb begin
      reg_rdata = '0;
      if (sel_ctrl) begin
         reg_rdata[CTL_EN]            = en_q;
         reg_rdata[CTL_RXTH +: TH_W]  = rx_th_q;
         reg_rdata[CTL_TXTH +: TH_W]  = tx_th_q;
      end else if (sel_stat) begin
         reg_rdata[7:0] = status;
      end else if (sel_mask) begin
         reg_rdata[SRC_LSB +: SRC_N] = mask;
      end else if (sel_data) begin
         reg_rdata = rx_head;
      end
   end
endmodule

// File: rtl/afs_irq_unit_chk.sv
module afs_irq_unit_chk #(
   parameter int DATA_W = 32,
   parameter int DEPTH  = 16
) (
   input logic                       clk,
   input logic                       rst_n,
   input logic                       rd_data,
   input logic                       wr_data,
   input logic                       rx_empty,
   input logic                       tx_full,
   input logic                       tx_out,
   input logic [DATA_W-1:0]          reg_rdata,
   input logic [$clog2(DEPTH+1)-1:0] rx_level,
   input logic [$clog2(DEPTH+1)-1:0] tx_level,
   input logic                       ovr,
   input logic                       ovr_clr,
   input logic                       flush,
   input logic [3:0]                 mask,
   input logic                       irq,
   input logic                       busy,
   input logic                       en
);
   localparam int LVL_W = $clog2(DEPTH + 1);

   a_r2_level_bound: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_level <= LVL_W'(DEPTH)) && (tx_level <= LVL_W'(DEPTH)));

   a_r3_empty_read_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_data && rx_empty) |-> (reg_rdata == '0));

   a_r3_full_write_dropped: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_data && tx_full && !tx_out) |=> (tx_level == LVL_W'(DEPTH)));

   a_r6_ovr_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      (ovr && !ovr_clr && !flush) |=> ovr);

   a_r9_no_irq_when_masked: assert property (@(posedge clk) disable iff (!rst_n)
      (mask == 4'b0) |-> !irq);

   a_r10_flush_empties: assert property (@(posedge clk) disable iff (!rst_n)
      flush |=> (rx_level == '0) && (tx_level == '0) && !ovr);

   a_r11_busy_needs_en: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> en);
endmodule

bind afs_irq_unit afs_irq_unit_chk #(.DATA_W(DATA_W), .DEPTH(DEPTH)) chk_i (
   .clk(clk), .rst_n(rst_n),
   .rd_data(reg_rd && sel_data), .wr_data(reg_wr && sel_data),
   .rx_empty(rx_empty), .tx_full(tx_full), .tx_out(tx_out),
   .reg_rdata(reg_rdata), .rx_level(rx_level), .tx_level(tx_level),
   .ovr(sticky[1]), .ovr_clr(u_flags.clr[1]), .flush(flush),
   .mask(mask), .irq(irq), .busy(busy), .en(en_q)
);

// File: tb/afs_irq_unit_tb.sv
module afs_irq_unit_tb_top;
   localparam logic [2:0] A_CTRL = 3'd0, A_STAT = 3'd1, A_MASK = 3'd2,
                          A_CLR = 3'd3, A_DATA = 3'd4;

   logic        clk = 1'b0, rst_n = 1'b0;
   logic        reg_wr = 0, reg_rd = 0, tx_pull = 0, rx_push = 0, frame_active = 0;
   logic [2:0]  reg_addr = '0;
   logic [31:0] reg_wdata = '0, rx_word = '0;
   logic [31:0] reg_rdata, tx_word;
   logic        irq, dma_rx_req, dma_tx_req;

   int checks = 0, errors = 0;
   bit finished = 0;
   logic [31:0] v;

   always #10 clk = ~clk;

   afs_irq_unit dut_i (
      .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
      .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
      .tx_pull(tx_pull), .tx_word(tx_word), .rx_push(rx_push), .rx_word(rx_word),
      .frame_active(frame_active), .irq(irq),
      .dma_rx_req(dma_rx_req), .dma_tx_req(dma_tx_req)
   );

   task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
      end
   endtask

   task automatic bus_wr(logic [2:0] a, logic [31:0] d);
      @(negedge clk);
      reg_wr = 1; reg_addr = a; reg_wdata = d;
      @(negedge clk);
      reg_wr = 0;
      #1;
   endtask

   task automatic bus_rd(logic [2:0] a, output logic [31:0] d);
      @(negedge clk);
      reg_rd = 1; reg_addr = a;
      #2 d = reg_rdata;
      @(negedge clk);
      reg_rd = 0;
      #1;
   endtask

   task automatic lpush(logic [31:0] w);
      @(negedge clk);
      rx_push = 1; rx_word = w;
      @(negedge clk);
      rx_push = 0;
      #1;
   endtask

   task automatic lpull(output logic [31:0] w);
      @(negedge clk);
      tx_pull = 1;
      #2 w = tx_word;
      @(negedge clk);
      tx_pull = 0;
      #1;
   endtask

   task automatic stat_bit(string req, int b, logic exp);
      logic [31:0] s;
      bus_rd(A_STAT, s);
      chk(req, 32'(s[b]), 32'(exp));
   endtask

   task automatic t_reset();
      bus_rd(A_STAT, v);
      chk("R1 status", v, 32'h99);
      chk("R1 irq", 32'(irq), 0);
      chk("R1 dma_rx", 32'(dma_rx_req), 1);
      chk("R1 dma_tx", 32'(dma_tx_req), 1);
      bus_rd(A_DATA, v);
      chk("R3 empty read", v, 0);
   endtask

   task automatic t_order();
      bus_wr(A_CTRL, 32'h0000_0001);
      bus_rd(A_CTRL, v);
      chk("R2 ctrl readback", v, 32'h1);
      for (int i = 0; i < 3; i++) bus_wr(A_DATA, 32'hA000 + i);
      for (int i = 0; i < 3; i++) begin
         lpull(v);
         chk("R2 tx order", v, 32'hA000 + i);
      end
      for (int i = 0; i < 16; i++) lpush(32'hB000 + i);
      stat_bit("R12 rx not empty", 1, 1);
      for (int i = 0; i < 16; i++) begin
         bus_rd(A_DATA, v);
         chk("R2 rx order", v, 32'hB000 + i);
      end
      stat_bit("R12 rx drained", 1, 0);
   endtask

   task automatic t_empty_full();
      bus_rd(A_DATA, v);
      chk("R3 empty read zero", v, 0);
      lpush(32'hC0DE);
      bus_rd(A_DATA, v);
      chk("R3 pointers kept", v, 32'hC0DE);
      for (int i = 0; i < 17; i++) bus_wr(A_DATA, 32'h100 + i);
      stat_bit("R12 tx full", 0, 0);
      for (int i = 0; i < 16; i++) begin
         lpull(v);
         chk("R3 full write dropped", v, 32'h100 + i);
      end
      stat_bit("R12 tx not full", 0, 1);
      stat_bit("R7 no underrun yet", 5, 0);
   endtask

   task automatic t_rx_thresh();
      bus_wr(A_CTRL, 32'h0000_4001);
      for (int i = 0; i < 3; i++) lpush(32'h300 + i);
      chk("R4 below threshold", 32'(dma_rx_req), 0);
      stat_bit("R4 status below", 4, 0);
      lpush(32'h303);
      chk("R4 at threshold", 32'(dma_rx_req), 1);
      stat_bit("R4 status at", 4, 1);
      for (int i = 0; i < 4; i++) bus_rd(A_DATA, v);
   endtask

   task automatic t_tx_thresh();
      bus_wr(A_CTRL, 32'h0000_0201);
      chk("R5 empty below", 32'(dma_tx_req), 1);
      for (int i = 0; i < 3; i++) bus_wr(A_DATA, 32'h400 + i);
      chk("R5 above threshold", 32'(dma_tx_req), 0);
      stat_bit("R5 status above", 3, 0);
      lpull(v);
      chk("R5 at threshold", 32'(dma_tx_req), 1);
      lpull(v);
      lpull(v);
   endtask

   task automatic t_overrun();
      bus_wr(A_CTRL, 32'h0000_0001);
      for (int i = 0; i < 17; i++) lpush(32'h200 + i);
      stat_bit("R6 overrun set", 6, 1);
      for (int i = 0; i < 16; i++) begin
         bus_rd(A_DATA, v);
         chk("R6 word lost", v, 32'h200 + i);
      end
      stat_bit("R6 overrun sticky", 6, 1);
   endtask

   task automatic t_irq();
      bus_wr(A_MASK, 32'h40);
      chk("R9 irq overrun", 32'(irq), 1);
      bus_wr(A_MASK, 32'h0);
      chk("R9 irq masked", 32'(irq), 0);
      bus_wr(A_MASK, 32'hFF);
      bus_rd(A_MASK, v);
      chk("R9 mask readback", v, 32'h78);
      bus_wr(A_MASK, 32'h08);
      chk("R9 irq tx svc", 32'(irq), 1);
      bus_wr(A_MASK, 32'h0);
   endtask

   task automatic t_clear();
      bus_wr(A_CLR, 32'h0);
      stat_bit("R8 zero write no effect", 6, 1);
      bus_wr(A_CLR, 32'h40);
      stat_bit("R8 overrun cleared", 6, 0);
      lpull(v);
      chk("R7 underrun word", v, 0);
      stat_bit("R7 underrun set", 5, 1);
      bus_wr(A_CLR, 32'h20);
      stat_bit("R8 underrun cleared", 5, 0);
      @(negedge clk);
      tx_pull = 1; reg_wr = 1; reg_addr = A_CLR; reg_wdata = 32'h20;
      @(negedge clk);
      tx_pull = 0; reg_wr = 0;
      #1;
      stat_bit("R8 set wins", 5, 1);
   endtask

   task automatic t_flush();
      lpush(32'h51);
      bus_wr(A_DATA, 32'h52);
      bus_wr(A_CTRL, 32'h0000_0009);
      stat_bit("R10 rx emptied", 1, 0);
      stat_bit("R10 flags cleared", 5, 0);
      bus_rd(A_DATA, v);
      chk("R10 rx data gone", v, 0);
      lpull(v);
      chk("R10 tx data gone", v, 0);
      bus_rd(A_CTRL, v);
      chk("R10 flush reads zero", v, 32'h1);
      bus_wr(A_CLR, 32'h60);
   endtask

   task automatic t_enable();
      frame_active = 1;
      stat_bit("R11 busy", 2, 1);
      bus_wr(A_CTRL, 32'h0);
      stat_bit("R11 off", 7, 1);
      stat_bit("R11 busy needs enable", 2, 0);
      lpush(32'h77);
      stat_bit("R11 push ignored", 1, 0);
      lpull(v);
      stat_bit("R11 pull ignored", 5, 0);
      frame_active = 0;
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1;
      t_reset();
      t_order();
      t_empty_full();
      t_rx_thresh();
      t_tx_thresh();
      t_overrun();
      t_irq();
      t_clear();
      t_flush();
      t_enable();
      if (!finished) begin
         finished = 1;
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!finished) begin
         finished = 1;
         checks++;
         errors++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end
endmodule